// File: doc/BRIEF.md
# Privileged control register file

This block is a bank of privileged processor control and status registers. A core reaches them through a numbered read port and a numbered write port. It keeps a processor state word, the current trap level, a set of per-level trap save stacks, and the trap base address and interrupt level. It also keeps a hypervisor state word, a strand status word, a floating-point status word, and the primary context, secondary context and partition identifiers. The rest of the bank is a load/store control word, eight scratch words and eight interrupt queue pointers.

Reads are combinational from the current state, so a read in the same cycle as a write returns the value from before the write. Writes take effect at the clock edge. Each register applies its own write mask. The trap save stacks are addressed by the current trap level minus one.

A write to the trap level can raise or drop a request for a trap-level-zero interrupt. A packed translation-control word is driven to the memory management unit at all times. Any access to a number that maps to nothing is answered with zero and a one-cycle error pulse.

Top module: `priv_ctl_regs`

## Requirements
- R1: A write to the processor state word (number 0x00) keeps only the bits in mask 0xBDE (bits 1, 2, 3, 4, 6, 7, 8, 9 and 11). Bit 2 is privilege and bit 3 is address mask. The other bits read back as zero.
- R2: A write to the trap base address (number 0x03) stores the value with bits 14:0 cleared.
- R3: The five trap save stacks each hold one 64-bit entry per trap level from 1 to MAX_TL (default 6). They are saved PC (0x08), saved next PC (0x09), saved state (0x0A), trap type (0x0B) and hypervisor saved state (0x0C). Reads and writes use the entry of level TL−1, and each entry is independent.
- R4: When TL is 0 or above MAX_TL, a stack number counts as unimplemented (R9): the read returns zero, the write is dropped, and acc_err pulses.
- R5: A write to the trap level (number 0x01) sets tlz_irq when hypervisor state bit 0 is 1, the new TL is 0 and hypervisor state bit 2 is 0. Any other TL write clears it. No other access changes tlz_irq.
- R6: After reset, the hypervisor state word (0x04) holds 0x800 and the strand status word (0x05) holds 0x50000. Every other register, tlz_irq, acc_err and mmu_ctl is 0.
- R7: mmu_ctl packs its fields as follows:
  - bit 0: hypervisor state bit 2
  - bit 1: hypervisor state bit 5
  - bit 2: state word bit 2
  - bit 3: state word bit 3
  - bits 5:4: load/store control (0x13) bits 3:2
  - bits 15:8: partition ID
  - bits 18:16: TL
  - bits 47:32: primary context
  - bits 63:48: secondary context
  - all other bits: zero
- R8: A read of the floating-point status word (0x06) returns the stored value with bits 1:0 forced to 1.
- R9: A read or write with a number outside the map returns zero and changes no state. acc_err is 1 in the cycle after such an access and 0 after a valid one.
- R10: When a read and a write hit the same number in the same cycle, the read returns the old value.
- R11: Some registers store only their low bits:
  - interrupt level (0x02): 4 bits
  - trap level: 3 bits
  - primary context (0x10): 16 bits
  - secondary context (0x11): 16 bits
  - partition ID (0x12): 8 bits

  The registers that store all 64 bits are 0x04, 0x05, 0x06, 0x13, the scratch words 0x18–0x1F and the queue pointers 0x20–0x27. Reads zero-extend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| rd_num | input | 8 | Register number to read |
| rd_data | output | 64 | Read value, combinational; zero when idle or unimplemented |
| wr_en | input | 1 | Write strobe |
| wr_num | input | 8 | Register number to write |
| wr_data | input | 64 | Write value |
| acc_err | output | 1 | One-cycle flag after an access to an unimplemented number |
| tlz_irq | output | 1 | Trap-level-zero interrupt request |
| mmu_ctl | output | 64 | Packed translation-control word |

## Verification
The assertions assume that rd_num and wr_num carry defined values whenever their strobes are high. They also assume that trap-level writes are judged on the low three bits only, so a stored TL of zero is the condition that counts. The bench always drives every strobe and number together at the falling edge, and it never leaves a number undefined. Its trap-level writes stay within 0 to 7, which lets it steer into both the in-range and the out-of-range stack cases on purpose.

// File: rtl/priv_ctl_regs.sv
module priv_ctl_regs #(
  parameter int MAX_TL = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic [7:0]  rd_num,
  output logic [63:0] rd_data,
  input  logic        wr_en,
  input  logic [7:0]  wr_num,
  input  logic [63:0] wr_data,
  output logic        acc_err,
  output logic        tlz_irq,
  output logic [63:0] mmu_ctl
);
  localparam int TLW = $clog2(MAX_TL + 1);
  localparam logic [63:0] STATE_KEEP = 64'hBDE;
  localparam logic [63:0] TBASE_KEEP = ~64'h7FFF;
  localparam logic [63:0] HST_RST    = 64'h800;
  localparam logic [63:0] STRAND_RST = 64'h50000;

  localparam logic [7:0] N_STATE  = 8'h00;
  localparam logic [7:0] N_TLVL   = 8'h01;
  localparam logic [7:0] N_PIL    = 8'h02;
  localparam logic [7:0] N_TBASE  = 8'h03;
  localparam logic [7:0] N_HSTATE = 8'h04;
  localparam logic [7:0] N_STRAND = 8'h05;
  localparam logic [7:0] N_FPST   = 8'h06;
  localparam logic [7:0] N_STK0   = 8'h08;
  localparam logic [7:0] N_STK4   = 8'h0C;
  localparam logic [7:0] N_PCTX   = 8'h10;
  localparam logic [7:0] N_SCTX   = 8'h11;
  localparam logic [7:0] N_PART   = 8'h12;
  localparam logic [7:0] N_LSU    = 8'h13;

  logic [63:0]    st_q, tba_q, hst_q, strand_q, fps_q, lsu_q;
  logic [TLW-1:0] tl_q;
  logic [3:0]     pil_q;
  logic [15:0]    pctx_q, sctx_q;
  logic [7:0]     part_q;
  logic [63:0]    scr_q [8];
  logic [63:0]    que_q [8];
  logic [63:0]    stk_q [5][MAX_TL];
  logic           tlz_q, err_q;

  logic [TLW-1:0] lvl;
  logic           stk_ok;
  logic [2:0]     tl3;

  assign lvl    = tl_q - TLW'(1);
  assign stk_ok = (tl_q != '0) && (int'(tl_q) <= MAX_TL);
  assign tl3    = 3'(tl_q);

  function automatic logic known(input logic [7:0] n, input logic sok);
    if (n inside {[8'h00:8'h06], [8'h10:8'h13], [8'h18:8'h27]}) return 1'b1;
    if (n inside {[N_STK0:N_STK4]}) return sok;
    return 1'b0;
  endfunction

  logic rd_ok, wr_ok;
  assign rd_ok = rd_en && known(rd_num, stk_ok);
  assign wr_ok = wr_en && known(wr_num, stk_ok);

  always_comb begin
    rd_data = '0;
    if (rd_ok) begin
      if (rd_num inside {[N_STK0:N_STK4]})
        rd_data = stk_q[3'(rd_num - N_STK0)][lvl];
      else if (rd_num inside {[8'h18:8'h1F]})
        rd_data = scr_q[rd_num[2:0]];
      else if (rd_num inside {[8'h20:8'h27]})
        rd_data = que_q[rd_num[2:0]];
      else begin
        case (rd_num)
          N_STATE:  rd_data = st_q;
          N_TLVL:   rd_data = 64'(tl_q);
          N_PIL:    rd_data = 64'(pil_q);
          N_TBASE:  rd_data = tba_q;
          N_HSTATE: rd_data = hst_q;
          N_STRAND: rd_data = strand_q;
          N_FPST:   rd_data = fps_q | 64'h3;
          N_PCTX:   rd_data = 64'(pctx_q);
          N_SCTX:   rd_data = 64'(sctx_q);
          N_PART:   rd_data = 64'(part_q);
          N_LSU:    rd_data = lsu_q;
          default:  rd_data = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0; tba_q <= '0; hst_q <= HST_RST; strand_q <= STRAND_RST;
      fps_q <= '0; lsu_q <= '0; tl_q <= '0; pil_q <= '0;
      pctx_q <= '0; sctx_q <= '0; part_q <= '0;
      tlz_q <= 1'b0; err_q <= 1'b0;
      for (int i = 0; i < 8; i++) begin
        scr_q[i] <= '0;
        que_q[i] <= '0;
      end
      for (int k = 0; k < 5; k++)
        for (int l = 0; l < MAX_TL; l++)
          stk_q[k][l] <= '0;
    end else begin
      err_q <= (rd_en && !rd_ok) || (wr_en && !wr_ok);
      if (wr_ok) begin
        if (wr_num inside {[N_STK0:N_STK4]})
          stk_q[3'(wr_num - N_STK0)][lvl] <= wr_data;
        else if (wr_num inside {[8'h18:8'h1F]})
          scr_q[wr_num[2:0]] <= wr_data;
        else if (wr_num inside {[8'h20:8'h27]})
          que_q[wr_num[2:0]] <= wr_data;
        else begin
          case (wr_num)
            N_STATE:  st_q <= wr_data & STATE_KEEP;
            N_TLVL: begin
              tl_q  <= wr_data[TLW-1:0];
              tlz_q <= hst_q[0] && (wr_data[TLW-1:0] == '0) && !hst_q[2];
            end
            N_PIL:    pil_q <= wr_data[3:0];
            N_TBASE:  tba_q <= wr_data & TBASE_KEEP;
            N_HSTATE: hst_q <= wr_data;
            N_STRAND: strand_q <= wr_data;
            N_FPST:   fps_q <= wr_data;
            N_PCTX:   pctx_q <= wr_data[15:0];
            N_SCTX:   sctx_q <= wr_data[15:0];
            N_PART:   part_q <= wr_data[7:0];
            N_LSU:    lsu_q <= wr_data;
            default:  ;
          endcase
        end
      end
    end
  end

  assign acc_err = err_q;
  assign tlz_irq = tlz_q;
  assign mmu_ctl = {sctx_q, pctx_q, 13'b0, tl3, part_q, 2'b0, lsu_q[3:2],
                    st_q[3], st_q[2], hst_q[5], hst_q[2]};

  p_state_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_num == N_STATE) |-> ((rd_data & ~STATE_KEEP) == '0));

  p_tbase_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_num == N_TBASE) |-> (rd_data[14:0] == '0));

  p_stk_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_num >= N_STK0 && rd_num <= N_STK4 && tl_q == '0) |=> acc_err);

  p_tlz_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_num == N_TLVL && wr_data[TLW-1:0] == '0 && hst_q[0] && !hst_q[2])
    |=> tlz_irq);

  p_tlz_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_num == N_TLVL && wr_data[TLW-1:0] != '0) |=> !tlz_irq);

  p_tlz_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_num == N_TLVL) |=> $stable(tlz_irq));

  p_fpst_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_num == N_FPST) |-> (rd_data[1:0] == 2'b11));

  p_bad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !known(rd_num, stk_ok)) |-> (rd_data == '0));

  p_bad_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !known(wr_num, stk_ok)) |=> acc_err);
endmodule

// File: tb/priv_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module priv_ctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  rd_num = '0, wr_num = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data, mmu_ctl;
  logic        acc_err, tlz_irq;
  int vectors = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  priv_ctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_num(rd_num), .rd_data(rd_data),
    .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data), .acc_err(acc_err),
    .tlz_irq(tlz_irq), .mmu_ctl(mmu_ctl));

  function automatic bit impl(input int n, input int tl);
    if (n >= 8 && n <= 12) return (tl >= 1 && tl <= 6);
    return (n <= 6) || (n >= 16 && n <= 19) || (n >= 24 && n <= 39);
  endfunction

  function automatic logic [63:0] rstv(input int n);
    if (n == 4) return 64'h800;
    if (n == 5) return 64'h50000;
    if (n == 6) return 64'h3;
    return 64'h0;
  endfunction

  function automatic logic [63:0] pat(input int n);
    return (64'(n) * 64'h0101_0101_0101_0101) ^ 64'hF00D_CAFE_1234_5678;
  endfunction

  function automatic logic [63:0] spat(input int k, input int t);
    return {16'(k + 1), 16'(t), 32'hA5A5_0000 + 32'(k * 16 + t)};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic re, input logic [7:0] rn, input logic we,
                       input logic [7:0] wn, input logic [63:0] wd);
    @(negedge clk);
    rd_en = re; rd_num = rn; wr_en = we; wr_num = wn; wr_data = wd;
    #1;
  endtask

  task automatic rd_chk(input string tag, input int n, input logic [63:0] exp, input bit experr);
    drive(1'b1, 8'(n), 1'b0, 8'h0, 64'h0);
    chk(tag, rd_data, exp);
    @(posedge clk); #1;
    chk({tag, " err"}, 64'(acc_err), 64'(experr));
  endtask

  task automatic wr(input int n, input logic [63:0] d);
    drive(1'b0, 8'h0, 1'b1, 8'(n), d);
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R6 reset outputs
    chk("R6 mmu", mmu_ctl, 64'h0);
    chk("R6 irq", 64'(tlz_irq), 64'h0);
    chk("R6 err", 64'(acc_err), 64'h0);
    // R6 / R9 / R4 sweep over every number at reset (TL = 0)
    for (int n = 0; n < 256; n++)
      rd_chk("R6_R9 sweep", n, impl(n, 0) ? rstv(n) : 64'h0, !impl(n, 0));

    // R11 scratch and queue words, full width
    for (int n = 24; n < 40; n++) wr(n, pat(n));
    for (int n = 24; n < 40; n++) rd_chk("R11 scratch/queue", n, pat(n), 1'b0);

    // R3 trap stacks per level
    for (int t = 1; t <= 6; t++) begin
      wr(1, 64'(t));
      for (int k = 0; k < 5; k++) wr(8 + k, spat(k, t));
    end
    for (int t = 6; t >= 1; t--) begin
      wr(1, 64'(t));
      for (int k = 0; k < 5; k++) rd_chk("R3 stack", 8 + k, spat(k, t), 1'b0);
    end
    // R4 out-of-range levels
    wr(1, 64'd7);
    rd_chk("R4 tl7 read", 8, 64'h0, 1'b1);
    drive(1'b0, 8'h0, 1'b1, 8'h08, 64'hDEAD); @(posedge clk); #1;
    chk("R4 tl7 write err", 64'(acc_err), 64'h1);
    wr(1, 64'd0);
    drive(1'b0, 8'h0, 1'b1, 8'h0B, 64'hBEEF); @(posedge clk); #1;
    chk("R4 tl0 write err", 64'(acc_err), 64'h1);
    wr(1, 64'd1);
    rd_chk("R4 entry kept", 8, spat(0, 1), 1'b0);
    rd_chk("R4 entry kept", 11, spat(3, 1), 1'b0);

    // R1 state word mask
    wr(0, '1);                     rd_chk("R1 ones", 0, 64'hBDE, 1'b0);
    wr(0, 64'h5555_5555_5555_5555); rd_chk("R1 alt", 0, 64'h5555_5555_5555_5555 & 64'hBDE, 1'b0);
    wr(0, 64'hFFFF_F421);          rd_chk("R1 drop", 0, 64'h0, 1'b0);

    // R2 trap base
    wr(3, '1);             rd_chk("R2 ones", 3, ~64'h7FFF, 1'b0);
    wr(3, 64'h1234_5678);  rd_chk("R2 val", 3, 64'h1234_5678 & ~64'h7FFF, 1'b0);

    // R8 floating-point status
    wr(6, 64'h0);   rd_chk("R8 zero", 6, 64'h3, 1'b0);
    wr(6, 64'hF0);  rd_chk("R8 f0", 6, 64'hF3, 1'b0);
    wr(6, 64'h1);   rd_chk("R8 one", 6, 64'h3, 1'b0);

    // R11 narrow registers
    wr(2, 64'hFF);      rd_chk("R11 pil", 2, 64'hF, 1'b0);
    wr(16, 64'h12345);  rd_chk("R11 pctx", 16, 64'h2345, 1'b0);
    wr(17, '1);         rd_chk("R11 sctx", 17, 64'hFFFF, 1'b0);
    wr(18, 64'h1FF);    rd_chk("R11 part", 18, 64'hFF, 1'b0);
    wr(1, 64'hF5);      rd_chk("R11 tl", 1, 64'h5, 1'b0);
    wr(5, 64'hCAFE_0000_0001); rd_chk("R11 strand", 5, 64'hCAFE_0000_0001, 1'b0);

    // R7 packed control word
    wr(4, 64'h824); wr(0, 64'hC); wr(19, 64'hC); wr(18, 64'hA5);
    wr(1, 64'd3); wr(16, 64'h1234); wr(17, 64'hBEEF);
    chk("R7 pack", mmu_ctl, 64'hBEEF_1234_0003_A53F);
    wr(4, 64'h800); wr(0, 64'h8); wr(19, 64'h4);
    chk("R7 pack2", mmu_ctl, 64'hBEEF_1234_0003_A518);

    // R5 trap-level-zero request
    wr(4, 64'h801);
    chk("R5 hstate alone", 64'(tlz_irq), 64'h0);
    wr(1, 64'd0);  chk("R5 set", 64'(tlz_irq), 64'h1);
    wr(24, 64'h1); chk("R5 hold", 64'(tlz_irq), 64'h1);
    wr(1, 64'd2);  chk("R5 clear", 64'(tlz_irq), 64'h0);
    wr(1, 64'd0);  chk("R5 set again", 64'(tlz_irq), 64'h1);
    wr(4, 64'h805);
    wr(1, 64'd0);  chk("R5 hpriv blocks", 64'(tlz_irq), 64'h0);
    wr(4, 64'h800);
    wr(1, 64'd0);  chk("R5 tlz off", 64'(tlz_irq), 64'h0);

    // R10 read-before-write
    wr(25, pat(25));
    drive(1'b1, 8'd25, 1'b1, 8'd25, 64'h1111_2222_3333_4444);
    chk("R10 old", rd_data, pat(25));
    @(posedge clk); #1;
    rd_chk("R10 new", 25, 64'h1111_2222_3333_4444, 1'b0);

    // R9 unimplemented writes leave state alone
    drive(1'b0, 8'h0, 1'b1, 8'h07, '1); @(posedge clk); #1;
    chk("R9 wr err", 64'(acc_err), 64'h1);
    drive(1'b0, 8'h0, 1'b1, 8'hFF, '1); @(posedge clk); #1;
    chk("R9 wr err ff", 64'(acc_err), 64'h1);
    rd_chk("R9 scratch kept", 25, 64'h1111_2222_3333_4444, 1'b0);
    rd_chk("R9 state kept", 0, 64'h8, 1'b0);
    chk("R9 mmu kept", mmu_ctl, 64'hBEEF_1234_0000_A518);

    drive(1'b0, 8'h0, 1'b0, 8'h0, 64'h0);
    @(posedge clk); #1;
    finish_run();
  end
endmodule